// File: doc/BRIEF.md
# Combined-Pending Interrupt Vector Generator

This block gathers interrupt requests from seven individual factors arranged in four groups: a single key line, a four-line key port, a clock timer with three rates and a stopwatch with two rates. Each factor has a sticky flag and an enable mask bit. A group counts as pending when any of its enabled flags is set.

When the core acknowledges the request, the block latches a vector address. This address is a base plus a four-bit bitmap of every group pending at that instant. One jump table of fifteen consecutive entries therefore covers every combination of groups. A separate fixed-priority index names the single most urgent enabled factor, so one shared handler can decide which factor to service first.

A small control state machine tracks the global enable. Its states are OFF, ARMED and SERVICE. The transitions are:
- GIE_ON: OFF to ARMED, on `gie_set`.
- GIE_OFF: ARMED to OFF, on `gie_clr`.
- TAKE: ARMED to SERVICE, on an accepted acknowledge.
- RETURN: SERVICE to ARMED, on `gie_set`.

Top module: `irq_vector_unit`

## Requirements
- R1: After reset, all flags are 0, `irq` is 0, `vec_addr` is 0x100, `prio_idx` is 0 and the control state is OFF.
- R2: Factor bit positions are: 0 single key, 1 key port, 2 timer 32 Hz, 3 timer 8 Hz, 4 timer 2 Hz, 5 stopwatch 10 Hz, 6 stopwatch 1 Hz. A 1 on `req_pulse[i]` at a clock edge sets `flags[i]` from that edge onward. The flag stays set until it is cleared.
- R3: When `clr_we` is 1 at an edge, every flag whose `clr_mask` bit is 1 is cleared. A request on the same bit in the same cycle wins, and the flag stays set.
- R4: A group is pending only through flags whose `fac_en` bit is 1. A set flag with its enable at 0 does not raise `irq` and does not appear in the vector.
- R5: `irq` is 1 exactly when the state is ARMED and at least one enabled flag is set. In OFF and SERVICE, `irq` is 0.
- R6: An `ack` while `irq` is 1 (TAKE) loads `vec_addr` with 0x100 plus a group bitmap. The bitmap weights are: single key 1, key port 2, any timer factor 4, any stopwatch factor 8. The values run from 0x101 to 0x10F. TAKE also moves the state to SERVICE, which drops `irq` on the next cycle.
- R7: `vec_addr` changes only on TAKE. Later requests, clears and an `ack` while `irq` is 0 leave it unchanged.
- R8: `prio_idx` reports the highest-priority enabled set flag as a rank from 1 to 7, or 0 when there is none. The ranks are: 1 stopwatch 10 Hz, 2 stopwatch 1 Hz, 3 key port, 4 single key, 5 timer 32 Hz, 6 timer 8 Hz, 7 timer 2 Hz.
- R9: `gie_set` moves OFF or SERVICE to ARMED. `gie_clr` moves ARMED to OFF. When `ack` and `gie_clr` arrive together with `irq` at 1, the acknowledge wins.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_pulse | input | 7 | One-cycle request per factor |
| fac_en | input | 7 | Enable mask per factor |
| gie_set | input | 1 | Set global interrupt enable |
| gie_clr | input | 1 | Clear global interrupt enable |
| ack | input | 1 | Interrupt acknowledge from the core |
| clr_we | input | 1 | Write strobe for flag clearing |
| clr_mask | input | 7 | Write-1-to-clear mask for the flags |
| irq | output | 1 | Interrupt request to the core |
| vec_addr | output | 12 | Latched vector address |
| flags | output | 7 | Raw sticky factor flags |
| prio_idx | output | 3 | Rank of the most urgent enabled flag |

## Verification
The vector is tried with several group patterns:
- Each group alone, which tells the four bitmap weights apart.
- All groups together, which reaches the top entry 0x10F.
- A timer-plus-key-port mix, which shows that bits combine rather than the highest bit winning.

Single factors inside the timer and stopwatch groups each raise their group bit, which exercises the group OR. Masking checks that disabled flags are left out of `irq` and the vector. A descending clear sequence walks the priority index through every rank. A long pseudo-random run then compares every output against the behavioural model on each clock.

// File: rtl/irqv_pkg.sv
package irqv_pkg;

    localparam int NUM_FACTORS = 7;
    localparam int NUM_GROUPS  = 4;
    localparam int RANK_W      = $clog2(NUM_FACTORS + 1);

    // factor bit positions
    localparam int F_KEY1  = 0;
    localparam int F_KPORT = 1;
    localparam int F_T32   = 2;
    localparam int F_T8    = 3;
    localparam int F_T2    = 4;
    localparam int F_SW10  = 5;
    localparam int F_SW1   = 6;

    typedef enum logic [1:0] {
        ST_OFF     = 2'd0,
        ST_ARMED   = 2'd1,
        ST_SERVICE = 2'd2
    } ctrl_state_t;

    // group bit (vector weight 2**g) that owns a factor
    function automatic int group_of(input int f);
        case (f)
            F_KEY1:             group_of = 0;
            F_KPORT:            group_of = 1;
            F_T32, F_T8, F_T2:  group_of = 2;
            default:            group_of = 3;
        endcase
    endfunction

    // factor that holds a given rank (1 = most urgent)
    function automatic int factor_at_rank(input int r);
        case (r)
            1:       factor_at_rank = F_SW10;
            2:       factor_at_rank = F_SW1;
            3:       factor_at_rank = F_KPORT;
            4:       factor_at_rank = F_KEY1;
            5:       factor_at_rank = F_T32;
            6:       factor_at_rank = F_T8;
            default: factor_at_rank = F_T2;
        endcase
    endfunction

endpackage

// File: rtl/irqv_flag_bank.sv
module irqv_flag_bank #(
    parameter int NF = 7
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic [NF-1:0] set_i,
    input  logic          clr_we,
    input  logic [NF-1:0] clr_mask,
    output logic [NF-1:0] flags_o
);

    for (genvar i = 0; i < NF; i++) begin : g_flag
        logic flag_q;
        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
                flag_q <= 1'b0;
            end else if (set_i[i]) begin
                flag_q <= 1'b1;              // request beats clear
            end else if (clr_we && clr_mask[i]) begin
                flag_q <= 1'b0;
            end
        end
        assign flags_o[i] = flag_q;
    end

    // R2: a request pulse leaves its flag set
    p_set_sticks_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (|set_i) |=> ((flags_o & $past(set_i)) == $past(set_i)));

    // R3: cleared bits without a competing request read 0
    p_clear_works_r3: assert property (@(posedge clk) disable iff (!rst_n)
        clr_we |=> ((flags_o & $past(clr_mask) & ~$past(set_i)) == '0));

endmodule

// File: rtl/irqv_group_map.sv
module irqv_group_map
    import irqv_pkg::*;
#(
    parameter int NF = NUM_FACTORS,
    parameter int NG = NUM_GROUPS,
    parameter int RW = RANK_W
) (
    input  logic [NF-1:0] flags_i,
    input  logic [NF-1:0] en_i,
    output logic [NG-1:0] grp_pend_o,
    output logic          any_pend_o,
    output logic [RW-1:0] prio_o
);

    logic [NF-1:0] active;
    assign active = flags_i & en_i;

    always_comb begin
        grp_pend_o = '0;
        for (int f = 0; f < NF; f++) begin
            if (active[f]) grp_pend_o[group_of(f)] = 1'b1;
        end
    end

    assign any_pend_o = |grp_pend_o;

    always_comb begin
        prio_o = '0;
        for (int r = NF; r >= 1; r--) begin
            if (active[factor_at_rank(r)]) prio_o = RW'(r);
        end
    end

endmodule

// File: rtl/irqv_ctrl.sv
module irqv_ctrl
    import irqv_pkg::*;
#(
    parameter int          NG       = NUM_GROUPS,
    parameter int          ADDR_W   = 12,
    parameter logic [11:0] VEC_BASE = 12'h100
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              gie_set,
    input  logic              gie_clr,
    input  logic              ack,
    input  logic              any_pend,
    input  logic [NG-1:0]     grp_pend,
    output logic              irq,
    output logic [ADDR_W-1:0] vec_addr,
    output ctrl_state_t       state
);

    localparam logic [ADDR_W-1:0] BASE = ADDR_W'(VEC_BASE);

    ctrl_state_t state_n;
    logic        take;

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state <= ST_OFF;
        else        state <= state_n;
    end

    // transitions: GIE_ON, GIE_OFF, TAKE, RETURN
    always_comb begin
        state_n = state;
        unique case (state)
            ST_OFF:     if (gie_set) state_n = ST_ARMED;
            ST_ARMED: begin
                if (take)         state_n = ST_SERVICE;
                else if (gie_clr) state_n = ST_OFF;
            end
            ST_SERVICE: if (gie_set) state_n = ST_ARMED;
            default:    state_n = ST_OFF;
        endcase
    end

    // outputs
    always_comb begin
        irq  = (state == ST_ARMED) && any_pend;
        take = irq && ack;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)    vec_addr <= BASE;
        else if (take) vec_addr <= BASE + ADDR_W'(grp_pend);
    end

    // R6: accepted acknowledge drops the request next cycle
    p_take_drops_irq_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (ack && irq) |=> (!irq && state == ST_SERVICE));

    // R6: a latched vector never carries an empty bitmap
    p_vec_nonzero_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (ack && irq) |=> (vec_addr != BASE));

    // R7: vector only moves on an accepted acknowledge
    p_vec_hold_r7: assert property (@(posedge clk) disable iff (!rst_n)
        !(ack && irq) |=> $stable(vec_addr));

    // R5: no request outside ARMED
    p_irq_armed_r5: assert property (@(posedge clk) disable iff (!rst_n)
        irq |-> (state == ST_ARMED));

    // R9: the disable request leaves ARMED when no acknowledge is taken
    p_gie_clr_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_ARMED && gie_clr && !(ack && irq)) |=> (state == ST_OFF));

endmodule

// File: rtl/irq_vector_unit.sv
module irq_vector_unit
    import irqv_pkg::*;
#(
    parameter int          ADDR_W   = 12,
    parameter logic [11:0] VEC_BASE = 12'h100
) (
    input  logic                   clk,
    input  logic                   rst_n,
    input  logic [NUM_FACTORS-1:0] req_pulse,
    input  logic [NUM_FACTORS-1:0] fac_en,
    input  logic                   gie_set,
    input  logic                   gie_clr,
    input  logic                   ack,
    input  logic                   clr_we,
    input  logic [NUM_FACTORS-1:0] clr_mask,
    output logic                   irq,
    output logic [ADDR_W-1:0]      vec_addr,
    output logic [NUM_FACTORS-1:0] flags,
    output logic [RANK_W-1:0]      prio_idx
);

    logic [NUM_GROUPS-1:0] grp_pend;
    logic                  any_pend;
    ctrl_state_t           state;

    irqv_flag_bank #(.NF(NUM_FACTORS)) u_flags (
        .clk      (clk),
        .rst_n    (rst_n),
        .set_i    (req_pulse),
        .clr_we   (clr_we),
        .clr_mask (clr_mask),
        .flags_o  (flags)
    );

    irqv_group_map #(.NF(NUM_FACTORS), .NG(NUM_GROUPS), .RW(RANK_W)) u_map (
        .flags_i    (flags),
        .en_i       (fac_en),
        .grp_pend_o (grp_pend),
        .any_pend_o (any_pend),
        .prio_o     (prio_idx)
    );

    irqv_ctrl #(.NG(NUM_GROUPS), .ADDR_W(ADDR_W), .VEC_BASE(VEC_BASE)) u_ctrl (
        .clk      (clk),
        .rst_n    (rst_n),
        .gie_set  (gie_set),
        .gie_clr  (gie_clr),
        .ack      (ack),
        .any_pend (any_pend),
        .grp_pend (grp_pend),
        .irq      (irq),
        .vec_addr (vec_addr),
        .state    (state)
    );

    // R4: a request needs an enabled set flag
    p_irq_needs_enable_r4: assert property (@(posedge clk) disable iff (!rst_n)
        irq |-> ((flags & fac_en) != '0));

    // R8: the rank is zero exactly when nothing enabled is set
    p_prio_zero_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (prio_idx == '0) == ((flags & fac_en) == '0));

endmodule

// File: tb/tb_irq_vector_unit.sv
module tb_irq_vector_unit;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [6:0]  req_pulse = '0, fac_en = '0, clr_mask = '0;
    logic        gie_set = 1'b0, gie_clr = 1'b0, ack = 1'b0, clr_we = 1'b0;
    logic        irq;
    logic [11:0] vec_addr;
    logic [6:0]  flags;
    logic [2:0]  prio_idx;

    int n_tests = 0, n_fail = 0;
    bit done = 1'b0;

    // behavioural model state
    logic [6:0]  m_flags = '0;
    int          m_state = 0;    // 0 off, 1 armed, 2 service
    logic [11:0] m_vec = 12'h100;

    always #4 clk = ~clk;

    irq_vector_unit dut (
        .clk(clk), .rst_n(rst_n), .req_pulse(req_pulse), .fac_en(fac_en),
        .gie_set(gie_set), .gie_clr(gie_clr), .ack(ack), .clr_we(clr_we),
        .clr_mask(clr_mask), .irq(irq), .vec_addr(vec_addr), .flags(flags),
        .prio_idx(prio_idx)
    );

    function automatic logic [3:0] m_groups(input logic [6:0] act);
        m_groups = {act[5] | act[6], act[2] | act[3] | act[4], act[1], act[0]};
    endfunction

    function automatic logic [2:0] m_rank(input logic [6:0] act);
        int order[7] = '{5, 6, 1, 0, 2, 3, 4};
        m_rank = 3'd0;
        foreach (order[k]) if (m_rank == 0 && act[order[k]]) m_rank = 3'(k + 1);
    endfunction

    task automatic chk(input string tag, input string what, input int act, input int exp);
        n_tests++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s %s actual=%0h expected=%0h", tag, what, act, exp);
        end
    endtask

    task automatic compare(input string tag);
        logic [6:0] act = m_flags & fac_en;
        chk(tag, "flags", int'(flags), int'(m_flags));
        chk(tag, "irq", int'(irq), int'(m_state == 1 && act != 0));
        chk(tag, "vec_addr", int'(vec_addr), int'(m_vec));
        chk(tag, "prio_idx", int'(prio_idx), int'(m_rank(act)));
    endtask

    task automatic step(input logic [6:0] rq, input logic [6:0] en, input logic gs,
                        input logic gc, input logic ak, input logic cw,
                        input logic [6:0] cm, input string tag);
        logic [6:0] act;
        logic       irq_now;
        logic [6:0] nf;
        int         ns;
        logic [11:0] nv;
        req_pulse = rq; fac_en = en; gie_set = gs; gie_clr = gc;
        ack = ak; clr_we = cw; clr_mask = cm;
        act = m_flags & en;
        irq_now = (m_state == 1) && (act != 0);
        nf = (m_flags & ~(cw ? cm : 7'h0)) | rq;
        ns = m_state;
        nv = m_vec;
        case (m_state)
            0: if (gs) ns = 1;
            1: if (ak && irq_now) begin ns = 2; nv = 12'h100 + 12'(m_groups(act)); end
               else if (gc) ns = 0;
            default: if (gs) ns = 1;
        endcase
        @(posedge clk);
        #2;
        m_flags = nf; m_state = ns; m_vec = nv;
        compare(tag);
    endtask

    task automatic idle(input string tag);
        step('0, fac_en, 0, 0, 0, 0, '0, tag);
    endtask

    task automatic clear_all(input string tag);
        step('0, fac_en, 0, 0, 0, 1, 7'h7F, tag);
    endtask

    initial begin : watchdog
        #(8 * 200000);
        if (!done) begin
            n_tests++; n_fail++;
            $display("FAIL watchdog expired");
            $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
            $finish;
        end
    end

    initial begin : stim
        logic [15:0] lfsr;
        repeat (3) @(posedge clk);
        #2;
        compare("R1");          // reset values
        rst_n = 1'b1;
        #8;
        compare("R1");

        // R5: flag set but OFF keeps irq low; R2 flag visible after one edge
        step(7'h01, 7'h7F, 0, 0, 0, 0, '0, "R2");
        idle("R5");
        chk("R5", "irq off", int'(irq), 0);
        step('0, 7'h7F, 1, 0, 0, 0, '0, "R9");     // GIE_ON
        chk("R5", "irq armed", int'(irq), 1);
        step('0, 7'h7F, 0, 0, 1, 0, '0, "R6");     // TAKE
        chk("R6", "vec single key", int'(vec_addr), 'h101);
        chk("R6", "irq after take", int'(irq), 0);

        // R7: new requests after TAKE do not move the vector
        step(7'h60, 7'h7F, 0, 0, 0, 0, '0, "R7");
        step('0, 7'h7F, 0, 0, 1, 0, '0, "R7");     // ack in SERVICE ignored
        chk("R7", "vec held", int'(vec_addr), 'h101);

        // R6: all groups -> 10F
        step(7'h1E, 7'h7F, 1, 0, 0, 0, '0, "R9");  // RETURN
        step('0, 7'h7F, 0, 0, 1, 0, '0, "R6");
        chk("R6", "vec all groups", int'(vec_addr), 'h10F);

        // R6: key port + timer 8 Hz -> 106
        clear_all("R3");
        step(7'h0A, 7'h7F, 1, 0, 0, 0, '0, "R6");
        step('0, 7'h7F, 0, 0, 1, 0, '0, "R6");
        chk("R6", "vec kport+timer", int'(vec_addr), 'h106);

        // R6: each stopwatch rate maps to weight 8; timer 2 Hz to 4
        clear_all("R3");
        step(7'h40, 7'h7F, 1, 0, 0, 0, '0, "R6");
        step('0, 7'h7F, 0, 0, 1, 0, '0, "R6");
        chk("R6", "vec stopwatch", int'(vec_addr), 'h108);
        clear_all("R3");
        step(7'h10, 7'h7F, 1, 0, 0, 0, '0, "R6");
        step('0, 7'h7F, 0, 0, 1, 0, '0, "R6");
        chk("R6", "vec timer 2Hz", int'(vec_addr), 'h104);

        // R4: masked timer flags: no irq, no timer bit in vector
        clear_all("R3");
        step(7'h1C, 7'h63, 1, 0, 0, 0, '0, "R4");
        chk("R4", "irq masked", int'(irq), 0);
        step(7'h02, 7'h63, 0, 0, 0, 0, '0, "R4");
        step('0, 7'h63, 0, 0, 1, 0, '0, "R4");
        chk("R4", "vec excludes masked", int'(vec_addr), 'h102);

        // R3: set wins over clear on the same bit
        step(7'h01, 7'h7F, 0, 0, 0, 1, 7'h03, "R3");
        chk("R3", "flags set-wins", int'(flags), 'h1D);

        // R8: walk the ranks by clearing from the top
        step(7'h7F, 7'h7F, 0, 0, 0, 0, '0, "R8");
        chk("R8", "rank all", int'(prio_idx), 1);
        step('0, 7'h7F, 0, 0, 0, 1, 7'h20, "R8");
        chk("R8", "rank sw1", int'(prio_idx), 2);
        step('0, 7'h7F, 0, 0, 0, 1, 7'h40, "R8");
        chk("R8", "rank kport", int'(prio_idx), 3);
        step('0, 7'h7F, 0, 0, 0, 1, 7'h02, "R8");
        chk("R8", "rank key1", int'(prio_idx), 4);
        step('0, 7'h7F, 0, 0, 0, 1, 7'h01, "R8");
        chk("R8", "rank t32", int'(prio_idx), 5);
        step('0, 7'h7F, 0, 0, 0, 1, 7'h04, "R8");
        chk("R8", "rank t8", int'(prio_idx), 6);
        step('0, 7'h7F, 0, 0, 0, 1, 7'h08, "R8");
        chk("R8", "rank t2", int'(prio_idx), 7);
        step('0, 7'h7F, 0, 0, 0, 1, 7'h10, "R8");
        chk("R8", "rank none", int'(prio_idx), 0);

        // R9: ARMED -> OFF; ack while irq low ignored (R7)
        step(7'h08, 7'h7F, 1, 0, 0, 0, '0, "R9");
        step('0, 7'h7F, 0, 1, 0, 0, '0, "R9");
        chk("R9", "irq after gie_clr", int'(irq), 0);
        step('0, 7'h7F, 0, 0, 1, 0, '0, "R7");
        chk("R7", "ack ignored", int'(vec_addr), 'h102);
        // R9: ack beats gie_clr
        step('0, 7'h7F, 1, 0, 0, 0, '0, "R9");
        step('0, 7'h7F, 0, 1, 1, 0, '0, "R9");
        chk("R9", "ack over clr", int'(vec_addr), 'h104);

        // pseudo-random run against the model
        lfsr = 16'hACE1;
        for (int i = 0; i < 400; i++) begin
            logic [6:0] rq, en, cm;
            lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
            rq = (lfsr[3:0] == 0) ? lfsr[10:4] : 7'h0;
            en = lfsr[8] ? 7'h7F : lfsr[15:9];
            cm = lfsr[13:7];
            step(rq, en, lfsr[1] & lfsr[5], lfsr[2] & lfsr[6] & lfsr[9],
                 lfsr[0], lfsr[11] & lfsr[12], cm, "R2 R6 R7 random");
        end

        done = 1'b1;
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

endmodule